// File: doc/BRIEF.md
# Power-Management Event and Sleep Controller

This block keeps the three 16-bit power-management registers of a platform: event status, event enable and sleep control. Hardware event pulses latch into the status register. Software clears status bits by writing ones to them. A level interrupt output stays high while any latched event is also enabled.

A write to the control register can carry a one-shot sleep request. The request bit is acted on in the write cycle and is never kept. The 3-bit sleep type field chooses the action: soft power-off, a suspend that resumes through a reset, or no action.

A separate command-byte port switches the interrupt-mode flag in the control register. When a configuration input allows it, the same port also fires a management-interrupt pulse. A power-button input either forces power-off, when power is failing, or latches a button event. The outputs go to platform logic that carries out the shutdown, reset and suspend.

Top module: `pm_evt_sleep`

## Requirements
- R1: While reset is active and in the first cycle after it, all three registers read 0, and `sciLevel`, `smiPulse`, `shutdownReq`, `resetReq` and `s3Ind` are 0.
- R2: The status register (`addr`=0) implements bits 0 (timer), 5 (global lock), 8 (power button), 10 (RTC) and 15 (wake); the other bits read 0. Writing a 1 clears that bit, and writing a 0 leaves it as it is. A hardware set in the same cycle as a clear wins.
- R3: A one-cycle pulse on `tmrEvt`, `gblEvt` or `rtcEvt` sets status bit 0, 5 or 10 at the next clock edge, whatever the enable register holds.
- R4: The enable register (`addr`=1) stores written bits 0, 5, 8 and 10; its other bits read 0.
- R5: `sciLevel` is 1 exactly when status and enable share a set bit among bits 0, 5, 8 and 10. It follows the registers with no extra cycle.
- R6: A write to the control register (`addr`=2) stores the written value with bit 13 (sleep request) forced to 0.
- R7: A control write with bit 13 set and bits 12:10 equal to 0 makes `shutdownReq` high for one cycle after the write edge.
- R8: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 and 8 and pulses `resetReq` for one cycle. It also raises `s3Ind`, which then stays high until reset.
- R9: A control write with bit 13 set and any other sleep type only updates the control register; no request output is raised.
- R10: On `apmWr`, command byte 0xF1 sets control bit 0 and 0xF0 clears it; other bytes leave it unchanged. If a bus control write happens in the same cycle, the command is applied after the written value.
- R11: `smiPulse` is high for one cycle after each `apmWr` cycle in which `smiCfgEn` is 1, and is 0 otherwise.
- R12: A `pwrBtnEvt` cycle with `pwrFailing` set pulses `shutdownReq`. Without `pwrFailing`, it sets status bit 8 only if enable bit 8 is set.
- R13: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select for read and write (0 status, 1 enable, 2 control, 3 none) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register (combinational) |
| apmWr | input | 1 | Command byte strobe |
| apmCmd | input | 8 | Command byte |
| smiCfgEn | input | 1 | Configuration bit allowing management-interrupt pulses |
| tmrEvt | input | 1 | Timer overflow event from the timer block |
| gblEvt | input | 1 | Global lock event |
| rtcEvt | input | 1 | Real-time clock alarm event |
| pwrBtnEvt | input | 1 | Power-button event |
| pwrFailing | input | 1 | Power is failing; qualifies the button event |
| sciLevel | output | 1 | Level system control interrupt |
| smiPulse | output | 1 | One-cycle management interrupt |
| shutdownReq | output | 1 | One-cycle soft power-off request |
| resetReq | output | 1 | One-cycle reset request for resume |
| s3Ind | output | 1 | Sticky suspend indication |

## Verification
The bench builds the block with its default command codes, 0xF1 for interrupt mode on and 0xF0 for off, and with sleep type 0 for power-off and 1 for suspend. These are the codes the requirements state, so the random command stream, biased toward the two codes, reaches both flag edges. It also reaches command bytes that must be ignored. Written sleep types are biased toward 0 and 1 and also cover the remaining six values. Writes often coincide with event pulses and command bytes, which exercises the set-over-clear rule and the same-cycle ordering of command and bus write.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int PM_W       = 16;
  localparam int SEL_W      = 2;
  localparam int CMD_W      = 8;
  localparam int TYP_W      = 3;

  localparam int BIT_TMR    = 0;
  localparam int BIT_GBL    = 5;
  localparam int BIT_BTN    = 8;
  localparam int BIT_RTC    = 10;
  localparam int BIT_WAK    = 15;
  localparam int BIT_SCIEN  = 0;
  localparam int BIT_SLPEN  = 13;
  localparam int TYP_LSB    = 10;

  localparam logic [PM_W-1:0] EVT_MASK =
    PM_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_BTN) | (1 << BIT_RTC));
  localparam logic [PM_W-1:0] STS_MASK = EVT_MASK | PM_W'(1 << BIT_WAK);
  localparam logic [PM_W-1:0] SLP_MASK = PM_W'(1 << BIT_SLPEN);

  typedef enum logic [SEL_W-1:0] {
    SEL_STS  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } pmSel_e;

  typedef struct packed {
    logic stsClr;
    logic enLoad;
    logic ctrlLoad;
    logic sciOn;
    logic sciOff;
    logic offReq;
    logic wakeReq;
    logic btnSet;
    logic smiFire;
  } pmStrobe_t;

endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter logic [CMD_W-1:0] APM_ON   = 8'hF1,
  parameter logic [CMD_W-1:0] APM_OFF  = 8'hF0,
  parameter logic [TYP_W-1:0] TYP_OFF  = 3'd0,
  parameter logic [TYP_W-1:0] TYP_WAKE = 3'd1
) (
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             slpReq,
  input  logic [TYP_W-1:0] slpTyp,
  input  logic             apmWr,
  input  logic [CMD_W-1:0] apmCmd,
  input  logic             smiCfgEn,
  input  logic             pwrBtnEvt,
  input  logic             pwrFailing,
  input  logic             btnEnable,
  output pmStrobe_t        strb
);

  logic ctrlHit;
  logic sleepGo;

  always_comb begin
    ctrlHit = wrEn && (pmSel_e'(wrSel) == SEL_CTRL);
    sleepGo = ctrlHit && slpReq;

    strb          = '0;
    strb.stsClr   = wrEn && (pmSel_e'(wrSel) == SEL_STS);
    strb.enLoad   = wrEn && (pmSel_e'(wrSel) == SEL_EN);
    strb.ctrlLoad = ctrlHit;
    strb.sciOn    = apmWr && (apmCmd == APM_ON);
    strb.sciOff   = apmWr && (apmCmd == APM_OFF);
    strb.wakeReq  = sleepGo && (slpTyp == TYP_WAKE);
    strb.offReq   = (sleepGo && (slpTyp == TYP_OFF)) ||
                    (pwrBtnEvt && pwrFailing);
    strb.btnSet   = pwrBtnEvt && !pwrFailing && btnEnable;
    strb.smiFire  = apmWr && smiCfgEn;
  end

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pmStrobe_t        strb,
  input  logic [PM_W-1:0]  wrData,
  input  logic [SEL_W-1:0] rdSel,
  input  logic             tmrEvt,
  input  logic             gblEvt,
  input  logic             rtcEvt,
  output logic [PM_W-1:0]  rdData,
  output logic [PM_W-1:0]  stsQ,
  output logic [PM_W-1:0]  enQ,
  output logic [PM_W-1:0]  ctrlQ,
  output logic             sciLevel,
  output logic             smiPulse,
  output logic             shutdownReq,
  output logic             resetReq,
  output logic             s3Ind
);

  logic [PM_W-1:0] setMask;
  logic [PM_W-1:0] stsBase;
  logic [PM_W-1:0] stsNext;
  logic [PM_W-1:0] enNext;
  logic [PM_W-1:0] ctrlNext;

  always_comb begin
    setMask          = '0;
    setMask[BIT_TMR] = tmrEvt;
    setMask[BIT_GBL] = gblEvt;
    setMask[BIT_RTC] = rtcEvt;
    setMask[BIT_BTN] = strb.btnSet || strb.wakeReq;
    setMask[BIT_WAK] = strb.wakeReq;

    stsBase = strb.stsClr ? (stsQ & ~wrData) : stsQ;
    stsNext = (stsBase | setMask) & STS_MASK;

    enNext = strb.enLoad ? (wrData & EVT_MASK) : enQ;

    ctrlNext = strb.ctrlLoad ? (wrData & ~SLP_MASK) : ctrlQ;
    if (strb.sciOn)
      ctrlNext[BIT_SCIEN] = 1'b1;
    else if (strb.sciOff)
      ctrlNext[BIT_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ        <= '0;
      enQ         <= '0;
      ctrlQ       <= '0;
      smiPulse    <= 1'b0;
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
      s3Ind       <= 1'b0;
    end else begin
      stsQ        <= stsNext;
      enQ         <= enNext;
      ctrlQ       <= ctrlNext;
      smiPulse    <= strb.smiFire;
      shutdownReq <= strb.offReq;
      resetReq    <= strb.wakeReq;
      s3Ind       <= s3Ind || strb.wakeReq;
    end
  end

  always_comb begin
    unique case (pmSel_e'(rdSel))
      SEL_STS:  rdData = stsQ;
      SEL_EN:   rdData = enQ;
      SEL_CTRL: rdData = ctrlQ;
      default:  rdData = '0;
    endcase
    sciLevel = |(stsQ & enQ & EVT_MASK);
  end

endmodule

// File: rtl/pm_evt_sleep.sv
module pm_evt_sleep
  import pm_evt_pkg::*;
#(
  parameter logic [7:0] APM_ON   = 8'hF1,
  parameter logic [7:0] APM_OFF  = 8'hF0,
  parameter logic [2:0] TYP_OFF  = 3'd0,
  parameter logic [2:0] TYP_WAKE = 3'd1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        apmWr,
  input  logic [7:0]  apmCmd,
  input  logic        smiCfgEn,
  input  logic        tmrEvt,
  input  logic        gblEvt,
  input  logic        rtcEvt,
  input  logic        pwrBtnEvt,
  input  logic        pwrFailing,
  output logic        sciLevel,
  output logic        smiPulse,
  output logic        shutdownReq,
  output logic        resetReq,
  output logic        s3Ind
);

  pmStrobe_t       strb;
  logic [PM_W-1:0] stsQ;
  logic [PM_W-1:0] enQ;
  logic [PM_W-1:0] ctrlQ;

  pm_evt_ctrl #(
    .APM_ON   (APM_ON),
    .APM_OFF  (APM_OFF),
    .TYP_OFF  (TYP_OFF),
    .TYP_WAKE (TYP_WAKE)
  ) u_ctrl (
    .wrEn       (wrEn),
    .wrSel      (addr),
    .slpReq     (wrData[BIT_SLPEN]),
    .slpTyp     (wrData[TYP_LSB +: TYP_W]),
    .apmWr      (apmWr),
    .apmCmd     (apmCmd),
    .smiCfgEn   (smiCfgEn),
    .pwrBtnEvt  (pwrBtnEvt),
    .pwrFailing (pwrFailing),
    .btnEnable  (enQ[BIT_BTN]),
    .strb       (strb)
  );

  pm_evt_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .rdSel       (addr),
    .tmrEvt      (tmrEvt),
    .gblEvt      (gblEvt),
    .rtcEvt      (rtcEvt),
    .rdData      (rdData),
    .stsQ        (stsQ),
    .enQ         (enQ),
    .ctrlQ       (ctrlQ),
    .sciLevel    (sciLevel),
    .smiPulse    (smiPulse),
    .shutdownReq (shutdownReq),
    .resetReq    (resetReq),
    .s3Ind       (s3Ind)
  );

endmodule

// File: rtl/pm_evt_sleep_chk.sv
module pm_evt_sleep_chk #(
  parameter logic [7:0] APM_ON  = 8'hF1,
  parameter logic [7:0] APM_OFF = 8'hF0
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  addr,
  input logic [15:0] wrData,
  input logic        apmWr,
  input logic [7:0]  apmCmd,
  input logic        smiCfgEn,
  input logic        pwrBtnEvt,
  input logic        pwrFailing,
  input logic [15:0] stsQ,
  input logic [15:0] enQ,
  input logic [15:0] ctrlQ,
  input logic        sciLevel,
  input logic        smiPulse,
  input logic        shutdownReq,
  input logic        resetReq,
  input logic        s3Ind
);

  logic ctrlWr;
  logic slpGo;
  assign ctrlWr = wrEn && (addr == 2'd2);
  assign slpGo  = ctrlWr && wrData[13];

  a_r5_sci_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == 16'h0000) |-> !sciLevel);

  a_r6_slp_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !apmWr) |=> (ctrlQ == ($past(wrData) & 16'hDFFF)));

  a_r7_soft_off: assert property (@(posedge clk) disable iff (!rstN)
    (slpGo && (wrData[12:10] == 3'd0)) |=> shutdownReq);

  a_r8_wake: assert property (@(posedge clk) disable iff (!rstN)
    (slpGo && (wrData[12:10] == 3'd1)) |=> (resetReq && s3Ind && stsQ[15] && stsQ[8]));

  a_r8_s3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    s3Ind |=> s3Ind);

  a_r9_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (slpGo && (wrData[12:10] > 3'd1) && !pwrBtnEvt) |=> (!resetReq && !shutdownReq));

  a_r10_apm_on: assert property (@(posedge clk) disable iff (!rstN)
    (apmWr && (apmCmd == APM_ON)) |=> ctrlQ[0]);

  a_r10_apm_off: assert property (@(posedge clk) disable iff (!rstN)
    (apmWr && (apmCmd == APM_OFF)) |=> !ctrlQ[0]);

  a_r11_smi_fire: assert property (@(posedge clk) disable iff (!rstN)
    (apmWr && smiCfgEn) |=> smiPulse);

  a_r11_smi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(apmWr && smiCfgEn) |=> !smiPulse);

  a_r12_fail_off: assert property (@(posedge clk) disable iff (!rstN)
    (pwrBtnEvt && pwrFailing) |=> shutdownReq);

endmodule

bind pm_evt_sleep pm_evt_sleep_chk #(
  .APM_ON  (APM_ON),
  .APM_OFF (APM_OFF)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .addr        (addr),
  .wrData      (wrData),
  .apmWr       (apmWr),
  .apmCmd      (apmCmd),
  .smiCfgEn    (smiCfgEn),
  .pwrBtnEvt   (pwrBtnEvt),
  .pwrFailing  (pwrFailing),
  .stsQ        (stsQ),
  .enQ         (enQ),
  .ctrlQ       (ctrlQ),
  .sciLevel    (sciLevel),
  .smiPulse    (smiPulse),
  .shutdownReq (shutdownReq),
  .resetReq    (resetReq),
  .s3Ind       (s3Ind)
);

// File: tb/pm_evt_sleep_bench.sv
module pm_evt_sleep_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  addr;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        apmWr;
  logic [7:0]  apmCmd;
  logic        smiCfgEn;
  logic        tmrEvt, gblEvt, rtcEvt, pwrBtnEvt, pwrFailing;
  logic        sciLevel, smiPulse, shutdownReq, resetReq, s3Ind;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  logic [15:0] mSts, mEn, mCtrl;
  logic        mS3;

  always #4 clk = ~clk;

  pm_evt_sleep u_pm_evt_sleep (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .apmWr(apmWr), .apmCmd(apmCmd), .smiCfgEn(smiCfgEn),
    .tmrEvt(tmrEvt), .gblEvt(gblEvt), .rtcEvt(rtcEvt),
    .pwrBtnEvt(pwrBtnEvt), .pwrFailing(pwrFailing),
    .sciLevel(sciLevel), .smiPulse(smiPulse), .shutdownReq(shutdownReq),
    .resetReq(resetReq), .s3Ind(s3Ind)
  );

  function automatic logic [15:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return mSts;
      2'd1:    return mEn;
      2'd2:    return mCtrl;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic expSci();
    return |(mSts & mEn & 16'h0521);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; addr = 0; wrData = 0; apmWr = 0; apmCmd = 0; smiCfgEn = 0;
    tmrEvt = 0; gblEvt = 0; rtcEvt = 0; pwrBtnEvt = 0; pwrFailing = 0;
  endtask

  task automatic doCycle(input logic we, input logic [1:0] a, input logic [15:0] d,
                         input logic aw, input logic [7:0] cmd, input logic cfg,
                         input logic te, input logic ge, input logic re,
                         input logic pb, input logic pf);
    logic [15:0] setM, nSts, nEn, nCtrl;
    logic wake, off, smi, ctrlW;
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; apmWr = aw; apmCmd = cmd; smiCfgEn = cfg;
    tmrEvt = te; gblEvt = ge; rtcEvt = re; pwrBtnEvt = pb; pwrFailing = pf;
    ctrlW = we && (a == 2'd2);
    wake  = ctrlW && d[13] && (d[12:10] == 3'd1);
    off   = (ctrlW && d[13] && (d[12:10] == 3'd0)) || (pb && pf);
    smi   = aw && cfg;
    setM  = 16'h0000;
    setM[0]  = te;
    setM[5]  = ge;
    setM[10] = re;
    setM[8]  = (pb && !pf && mEn[8]) || wake;
    setM[15] = wake;
    nSts  = (((we && a == 2'd0) ? (mSts & ~d) : mSts) | setM) & 16'h8521;
    nEn   = (we && a == 2'd1) ? (d & 16'h0521) : mEn;
    nCtrl = ctrlW ? (d & 16'hDFFF) : mCtrl;
    if (aw && cmd == 8'hF1) nCtrl[0] = 1'b1;
    else if (aw && cmd == 8'hF0) nCtrl[0] = 1'b0;
    @(posedge clk);
    #1;
    mSts = nSts; mEn = nEn; mCtrl = nCtrl; mS3 = mS3 || wake;
    case (a)
      2'd0:    chk("R2 status read", rdData, expRead(a));
      2'd1:    chk("R4 enable read", rdData, expRead(a));
      2'd2:    chk("R6 control read", rdData, expRead(a));
      default: chk("R13 unmapped read", rdData, expRead(a));
    endcase
    chk("R5 sciLevel", {15'd0, sciLevel}, {15'd0, expSci()});
    chk("R7 shutdownReq", {15'd0, shutdownReq}, {15'd0, off});
    chk("R8 resetReq", {15'd0, resetReq}, {15'd0, wake});
    chk("R8 s3Ind", {15'd0, s3Ind}, {15'd0, mS3});
    chk("R11 smiPulse", {15'd0, smiPulse}, {15'd0, smi});
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      idle();
      addr = 2'(i);
      #1;
      chk(tag, rdData, expRead(2'(i)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  c;
    void'($urandom(32'd20240611));
    idle();
    rstN = 1'b0;
    mSts = 0; mEn = 0; mCtrl = 0; mS3 = 0;
    repeat (3) @(posedge clk);
    // R1: reset state
    readAll("R1 reset register");
    chk("R1 reset outputs", {11'd0, sciLevel, smiPulse, shutdownReq, resetReq, s3Ind}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    readAll("R1 after reset register");

    // R3: event pulses latch with enable clear; R5 stays low
    doCycle(0, 2'd0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    doCycle(0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R4: enable write, R5 interrupt rises
    doCycle(1, 2'd1, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: W1C with a same-cycle timer set (set wins)
    doCycle(1, 2'd0, 16'hFFFF, 0, 0, 0, 1, 0, 0, 0, 0);
    doCycle(1, 2'd0, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0);
    // R12: button with enable set, then power failing
    doCycle(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    doCycle(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R12: button with enable clear leaves status bit 8 alone
    doCycle(1, 2'd1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
    doCycle(1, 2'd0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    doCycle(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R13: address 3 write ignored
    doCycle(1, 2'd3, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    readAll("R13 write ignored");
    // R6/R9: sleep type 5 stored without bit 13 and no request
    doCycle(1, 2'd2, 16'h3401, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: command after same-cycle control write, unknown command
    doCycle(1, 2'd2, 16'h0001, 1, 8'hF0, 1, 0, 0, 0, 0, 0);
    doCycle(0, 2'd2, 0, 1, 8'hF1, 0, 0, 0, 0, 0, 0);
    doCycle(0, 2'd2, 0, 1, 8'h33, 1, 0, 0, 0, 0, 0);
    // R7: soft power-off, then quiet cycle
    doCycle(1, 2'd2, 16'h2000, 0, 0, 0, 0, 0, 0, 0, 0);
    doCycle(0, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: suspend with resume
    doCycle(1, 2'd2, 16'h2400, 0, 0, 0, 0, 0, 0, 0, 0);
    doCycle(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      d = 16'($urandom);
      case ($urandom % 4)
        0: d[12:10] = 3'd0;
        1: d[12:10] = 3'd1;
        default: ;
      endcase
      d[13] = (($urandom % 4) == 0);
      case ($urandom % 3)
        0: c = 8'hF0;
        1: c = 8'hF1;
        default: c = 8'($urandom);
      endcase
      doCycle(($urandom % 3) == 0, 2'($urandom), d,
              ($urandom % 5) == 0, c, ($urandom % 2) == 0,
              ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
              ($urandom % 10) == 0, ($urandom % 4) == 0);
    end

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule